// File: doc/BRIEF.md
# Low-Power Sleep Mode Controller

This block tracks the power mode of a processor core across three states: full-speed run, low-power run and low-power sleep. From low-power run, a wait-for-interrupt instruction, a wait-for-event instruction or a return from an interrupt handler can move the core into low-power sleep. Each of these requests first has to pass its own guard condition. While the core sleeps, its clock gate is closed. The block watches the wake sources that belong to the way sleep was entered, and reopens the gate in the same cycle a valid wake appears.

The core provides single-cycle strobes for the two wait instructions and for the handler return. It also drives static control bits: deep-sleep select, sleep-on-exit and send-event-on-pending. An interrupt controller supplies two pending vectors. One holds enabled pending interrupts; the other holds every pending line, enabled or not. An event input and an event-pending flag complete the wake sources. A level request moves the core between full-speed run and low-power run. An entry request made outside low-power run has no effect and sets a sticky error flag.

Top module: `lps_mode_ctrl`

## Requirements
- R1: While reset is asserted (synchronous, active low) and afterwards until a request arrives, the mode output is 0 (run), the clock gate enable is 1, and the wake strobe and error flag are 0. Mode encoding: 0 = run, 1 = low-power run, 2 = low-power sleep.
- R2: Outside sleep, the mode moves to low-power run one cycle after the run-level request is seen at 1, and back to run one cycle after it is seen at 0. During sleep this request is ignored.
- R3: A wait-for-interrupt strobe in low-power run enters sleep on the next cycle only if deep-sleep select is 0 and no enabled interrupt is pending. Otherwise the mode stays low-power run.
- R4: A wait-for-event strobe in low-power run enters sleep on the next cycle only if deep-sleep select is 0 and the event-pending flag is 0.
- R5: A handler-return strobe in low-power run enters sleep only if deep-sleep select is 0, sleep-on-exit is 1 and no enabled interrupt is pending.
- R6: A wait strobe, or a handler return with sleep-on-exit at 1, that arrives in any mode other than low-power run leaves the mode unchanged. It sets the error flag, which stays at 1 until reset.
- R7: Sleep entered by wait-for-interrupt or by handler return ends only on an enabled pending interrupt. Events and disabled interrupts do not end it.
- R8: Sleep entered by wait-for-event with send-event-on-pending at 0 ends on the event input or on an enabled pending interrupt. A disabled interrupt that becomes pending does not end it.
- R9: Sleep entered by wait-for-event with send-event-on-pending at 1 also ends when any interrupt line, enabled or not, newly becomes pending. A line that was already pending when sleep began does not end it.
- R10: In the cycle a valid wake condition is present, the wake strobe is 1 and the clock gate enable is 1. On the next cycle the mode is low-power run.
- R11: The clock gate enable is 0 in every sleep cycle without a wake, and 1 in run and low-power run.
- R12: When several entry strobes arrive together, only the highest-priority one is evaluated: wait-for-interrupt first, then wait-for-event, then handler return. It also sets the wake rule.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lp_run_req_i | input | 1 | Level request for low-power run |
| wfi_i | input | 1 | Wait-for-interrupt executed strobe |
| wfe_i | input | 1 | Wait-for-event executed strobe |
| isr_ret_i | input | 1 | Interrupt handler return strobe |
| deep_sel_i | input | 1 | Deep-sleep select |
| sleep_on_exit_i | input | 1 | Sleep on handler return enable |
| sev_on_pend_i | input | 1 | Any new pending interrupt counts as event |
| irq_en_pend_i | input | NUM_IRQ | Enabled pending interrupt lines |
| irq_raw_pend_i | input | NUM_IRQ | All pending interrupt lines, enabled or not |
| evt_pend_i | input | 1 | Event already pending |
| evt_i | input | 1 | Event input |
| mode_o | output | 2 | Current power mode |
| core_clk_en_o | output | 1 | Core clock gate enable |
| wake_o | output | 1 | Wake strobe |
| seq_err_o | output | 1 | Sticky misplaced-request flag |

## Verification
The hardest case to reach is a wait-for-event sleep with send-event-on-pending set while a disabled interrupt line is already pending. Only a different line rising may wake the core. To reach it, the stimulus raises a raw line before the strobe, holds it through entry and one quiet sleep cycle, then raises a second line. A second hard case applies two entry strobes at once. The one with lower priority would succeed, but the winning one is blocked, so the core must not sleep. The stimulus then repeats both strobes without the blocking condition and checks that an event does not wake the resulting sleep.

// File: rtl/lps_pkg.sv
`timescale 1ns/1ps
// Shared types for the low-power sleep mode controller.
package lps_pkg;
    typedef enum logic [1:0] {
        MODE_RUN     = 2'd0,
        MODE_LPRUN   = 2'd1,
        MODE_LPSLEEP = 2'd2
    } lps_mode_e;

    typedef enum logic [1:0] {
        ENT_NONE = 2'd0,
        ENT_WFI  = 2'd1,
        ENT_WFE  = 2'd2,
        ENT_RET  = 2'd3
    } lps_entry_e;
endpackage

// File: rtl/lps_entry_dec.sv
`timescale 1ns/1ps
// Entry decoder: picks the highest-priority entry strobe and checks its guard.
// Produces an accepted entry and its method, plus a misplaced-request flag.
// Assumes strobes are one cycle wide and that in_lprun_i reflects the state register.
module lps_entry_dec
    import lps_pkg::*;
(
    input  logic       in_lprun_i,
    input  logic       wfi_i,
    input  logic       wfe_i,
    input  logic       isr_ret_i,
    input  logic       deep_sel_i,
    input  logic       sleep_on_exit_i,
    input  logic       irq_any_en_i,
    input  logic       evt_pend_i,
    output logic       enter_o,
    output lps_entry_e method_o,
    output logic       bad_req_o
);
    logic guard_ok;

    // Priority select and guard evaluation of the winning request.
    always_comb begin
        method_o = ENT_NONE;
        guard_ok = 1'b0;
        if (wfi_i) begin
            method_o = ENT_WFI;
            guard_ok = !deep_sel_i && !irq_any_en_i;
        end else if (wfe_i) begin
            method_o = ENT_WFE;
            guard_ok = !deep_sel_i && !evt_pend_i;
        end else if (isr_ret_i) begin
            method_o = ENT_RET;
            guard_ok = !deep_sel_i && sleep_on_exit_i && !irq_any_en_i;
        end
    end

    // Accept only from low-power run; flag requests seen elsewhere.
    always_comb begin
        enter_o   = in_lprun_i && guard_ok;
        bad_req_o = !in_lprun_i && (wfi_i || wfe_i || (isr_ret_i && sleep_on_exit_i));
    end
endmodule

// File: rtl/lps_wake_eval.sv
`timescale 1ns/1ps
// Wake evaluator: applies the wake rule that belongs to the recorded entry method.
// Detects lines of the raw pending vector that rise, for the
// send-event-on-pending rule. Wake is combinational so the gate reopens at once.
module lps_wake_eval
    import lps_pkg::*;
#(
    parameter int NUM_IRQ = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_sleep_i,
    input  lps_entry_e         method_i,
    input  logic               sev_on_pend_i,
    input  logic [NUM_IRQ-1:0] irq_en_pend_i,
    input  logic [NUM_IRQ-1:0] irq_raw_pend_i,
    input  logic               evt_i,
    output logic               wake_o
);
    logic [NUM_IRQ-1:0] raw_q;
    logic [NUM_IRQ-1:0] raw_new;
    logic               en_any;
    logic               cond;

    // Remember last cycle's raw pending vector for rise detection.
    always_ff @(posedge clk) begin
        if (!rst_n) raw_q <= '0;
        else        raw_q <= irq_raw_pend_i;
    end

    // Per-line rise detection of the raw pending vector.
    for (genvar g = 0; g < NUM_IRQ; g++) begin : g_rise
        assign raw_new[g] = irq_raw_pend_i[g] && !raw_q[g];
    end

    // Method-dependent wake condition.
    always_comb begin
        en_any = |irq_en_pend_i;
        case (method_i)
            ENT_WFI, ENT_RET: cond = en_any;
            ENT_WFE:          cond = evt_i || en_any || (sev_on_pend_i && (|raw_new));
            default:          cond = 1'b0;
        endcase
        wake_o = in_sleep_i && cond;
    end
endmodule

// File: rtl/lps_mode_fsm.sv
`timescale 1ns/1ps
// Mode state machine: holds the power mode, the entry method and the sticky error.
// Assumes enter_i is only raised in low-power run and wake_i only in sleep.
module lps_mode_fsm
    import lps_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       lp_run_req_i,
    input  logic       enter_i,
    input  lps_entry_e method_i,
    input  logic       bad_req_i,
    input  logic       wake_i,
    output lps_mode_e  mode_o,
    output lps_entry_e method_o,
    output logic       err_o
);
    lps_mode_e  mode_q;
    lps_entry_e meth_q;
    logic       err_q;

    // Mode and entry method transitions.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= MODE_RUN;
            meth_q <= ENT_NONE;
        end else begin
            case (mode_q)
                MODE_RUN: begin
                    if (lp_run_req_i) mode_q <= MODE_LPRUN;
                end
                MODE_LPRUN: begin
                    if (enter_i) begin
                        mode_q <= MODE_LPSLEEP;
                        meth_q <= method_i;
                    end else if (!lp_run_req_i) begin
                        mode_q <= MODE_RUN;
                    end
                end
                MODE_LPSLEEP: begin
                    if (wake_i) begin
                        mode_q <= MODE_LPRUN;
                        meth_q <= ENT_NONE;
                    end
                end
                default: mode_q <= MODE_RUN;
            endcase
        end
    end

    // Sticky misplaced-request flag.
    always_ff @(posedge clk) begin
        if (!rst_n) err_q <= 1'b0;
        else        err_q <= err_q || bad_req_i;
    end

    assign mode_o   = mode_q;
    assign method_o = meth_q;
    assign err_o    = err_q;

    assert_entry_from_lprun_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mode_q == MODE_LPSLEEP) |-> $past(mode_q) == MODE_LPRUN);
    assert_err_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        err_q |=> err_q);
    assert_wake_to_lprun_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == MODE_LPSLEEP && wake_i) |=> mode_q == MODE_LPRUN);
    assert_sleep_holds_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == MODE_LPSLEEP && !wake_i) |=> mode_q == MODE_LPSLEEP);
endmodule

// File: rtl/lps_mode_ctrl.sv
`timescale 1ns/1ps
// Top of the low-power sleep mode controller: entry decode, wake evaluation
// and mode state. Clock gate enable opens combinationally on wake (zero latency).
module lps_mode_ctrl
    import lps_pkg::*;
#(
    parameter int NUM_IRQ = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               lp_run_req_i,
    input  logic               wfi_i,
    input  logic               wfe_i,
    input  logic               isr_ret_i,
    input  logic               deep_sel_i,
    input  logic               sleep_on_exit_i,
    input  logic               sev_on_pend_i,
    input  logic [NUM_IRQ-1:0] irq_en_pend_i,
    input  logic [NUM_IRQ-1:0] irq_raw_pend_i,
    input  logic               evt_pend_i,
    input  logic               evt_i,
    output logic [1:0]         mode_o,
    output logic               core_clk_en_o,
    output logic               wake_o,
    output logic               seq_err_o
);
    lps_mode_e  mode;
    lps_entry_e cur_method;
    lps_entry_e new_method;
    logic       enter;
    logic       bad_req;
    logic       wake;
    logic       err;

    lps_entry_dec u_entry (
        .in_lprun_i      (mode == MODE_LPRUN),
        .wfi_i           (wfi_i),
        .wfe_i           (wfe_i),
        .isr_ret_i       (isr_ret_i),
        .deep_sel_i      (deep_sel_i),
        .sleep_on_exit_i (sleep_on_exit_i),
        .irq_any_en_i    (|irq_en_pend_i),
        .evt_pend_i      (evt_pend_i),
        .enter_o         (enter),
        .method_o        (new_method),
        .bad_req_o       (bad_req)
    );

    lps_wake_eval #(.NUM_IRQ(NUM_IRQ)) u_wake (
        .clk            (clk),
        .rst_n          (rst_n),
        .in_sleep_i     (mode == MODE_LPSLEEP),
        .method_i       (cur_method),
        .sev_on_pend_i  (sev_on_pend_i),
        .irq_en_pend_i  (irq_en_pend_i),
        .irq_raw_pend_i (irq_raw_pend_i),
        .evt_i          (evt_i),
        .wake_o         (wake)
    );

    lps_mode_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .lp_run_req_i (lp_run_req_i),
        .enter_i      (enter),
        .method_i     (new_method),
        .bad_req_i    (bad_req),
        .wake_i       (wake),
        .mode_o       (mode),
        .method_o     (cur_method),
        .err_o        (err)
    );

    // Output drive: gate closed only in sleep without a wake this cycle.
    always_comb begin
        mode_o        = mode;
        wake_o        = wake;
        core_clk_en_o = (mode != MODE_LPSLEEP) || wake;
        seq_err_o     = err;
    end

    assert_deep_blocks_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == 2'd1 && deep_sel_i) |=> mode_o != 2'd2);
    assert_sleep_keeps_mode_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == 2'd2) |=> mode_o != 2'd0);
endmodule

// File: tb/lps_mode_ctrl_tb_top.sv
`timescale 1ns/1ps
module lps_mode_ctrl_tb_top;
    localparam int N = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         lp_run_req, wfi, wfe, isr_ret, deep_sel, soe, sev, evt_pend, evt;
    logic [N-1:0] irq_en, irq_raw;
    logic [1:0]   mode;
    logic         clk_en, wake, err;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    typedef struct {
        logic [1:0] mode;
        logic       clk_en;
        logic       wake;
        logic       err;
        string      tag;
    } exp_t;
    exp_t sb_q[$];

    always #2 clk = ~clk;

    lps_mode_ctrl #(.NUM_IRQ(N)) dut_i (
        .clk(clk), .rst_n(rst_n), .lp_run_req_i(lp_run_req), .wfi_i(wfi), .wfe_i(wfe),
        .isr_ret_i(isr_ret), .deep_sel_i(deep_sel), .sleep_on_exit_i(soe),
        .sev_on_pend_i(sev), .irq_en_pend_i(irq_en), .irq_raw_pend_i(irq_raw),
        .evt_pend_i(evt_pend), .evt_i(evt), .mode_o(mode), .core_clk_en_o(clk_en),
        .wake_o(wake), .seq_err_o(err)
    );

    // Monitor: compares outputs one ns after each falling edge against the queue.
    always @(negedge clk) begin
        #1;
        if (sb_q.size() > 0) begin
            exp_t e;
            e = sb_q.pop_front();
            n_cmp++;
            if (mode !== e.mode || clk_en !== e.clk_en || wake !== e.wake || err !== e.err) begin
                n_bad++;
                $display("FAIL %s: got mode=%0d en=%0b wake=%0b err=%0b exp mode=%0d en=%0b wake=%0b err=%0b",
                         e.tag, mode, clk_en, wake, err, e.mode, e.clk_en, e.wake, e.err);
            end
        end
    end

    // Driver step: queue the expected outputs for this cycle, then advance.
    task automatic step(input logic [1:0] m, input logic en, input logic w, input logic er,
                        input string tag);
        exp_t e;
        e.mode = m; e.clk_en = en; e.wake = w; e.err = er; e.tag = tag;
        sb_q.push_back(e);
        @(negedge clk);
    endtask

    task automatic clear_strobes();
        wfi = 0; wfe = 0; isr_ret = 0; evt = 0;
        irq_en = '0; irq_raw = '0; evt_pend = 0;
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: got timeout exp completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        lp_run_req = 0; deep_sel = 0; soe = 0; sev = 0;
        clear_strobes();
        @(negedge clk); @(negedge clk);
        step(2'd0, 1, 0, 0, "R1 reset state");
        rst_n = 1;
        step(2'd0, 1, 0, 0, "R1 idle after reset");

        // R2 enter low-power run
        lp_run_req = 1;
        step(2'd0, 1, 0, 0, "R2 request seen");
        step(2'd1, 1, 0, 0, "R2 now low-power run");

        // R3 blocked by deep-sleep select, then by pending interrupt
        deep_sel = 1; wfi = 1;
        step(2'd1, 1, 0, 0, "R3 wfi deep");
        wfi = 0;
        step(2'd1, 1, 0, 0, "R3 deep blocks entry");
        deep_sel = 0; wfi = 1; irq_en = 8'h10;
        step(2'd1, 1, 0, 0, "R3 wfi with pending");
        clear_strobes();
        step(2'd1, 1, 0, 0, "R3 pending blocks entry");

        // R3/R7/R10/R11 WFI sleep, event and disabled irq do not wake
        wfi = 1;
        step(2'd1, 1, 0, 0, "R3 wfi accepted");
        wfi = 0;
        step(2'd2, 0, 0, 0, "R11 gate closed in sleep");
        evt = 1;
        step(2'd2, 0, 0, 0, "R7 event ignored after wfi");
        evt = 0; irq_raw = 8'h02;
        step(2'd2, 0, 0, 0, "R7 disabled irq ignored");
        irq_en = 8'h02;
        step(2'd2, 1, 1, 0, "R10 wake same cycle");
        clear_strobes();
        step(2'd1, 1, 0, 0, "R10 back in low-power run");

        // R4 WFE blocked by pending event and by deep select
        wfe = 1; evt_pend = 1;
        step(2'd1, 1, 0, 0, "R4 wfe with event pending");
        clear_strobes();
        step(2'd1, 1, 0, 0, "R4 pending event blocks");
        wfe = 1; deep_sel = 1;
        step(2'd1, 1, 0, 0, "R4 wfe deep");
        wfe = 0; deep_sel = 0;
        step(2'd1, 1, 0, 0, "R4 deep blocks wfe");

        // R8 WFE without send-event-on-pending
        wfe = 1;
        step(2'd1, 1, 0, 0, "R4 wfe accepted");
        wfe = 0;
        step(2'd2, 0, 0, 0, "R4 in sleep");
        irq_raw = 8'h04;
        step(2'd2, 0, 0, 0, "R8 new disabled irq ignored");
        evt = 1;
        step(2'd2, 1, 1, 0, "R8 event wakes");
        clear_strobes();
        step(2'd1, 1, 0, 0, "R8 returned");
        wfe = 1;
        step(2'd1, 1, 0, 0, "R8 wfe again");
        wfe = 0;
        step(2'd2, 0, 0, 0, "R8 sleeping");
        irq_en = 8'h80;
        step(2'd2, 1, 1, 0, "R8 enabled irq wakes");
        clear_strobes();
        step(2'd1, 1, 0, 0, "R8 returned again");

        // R9 WFE with send-event-on-pending; old pending line does not wake
        sev = 1; irq_raw = 8'h01; wfe = 1;
        step(2'd1, 1, 0, 0, "R9 wfe with sev");
        wfe = 0;
        step(2'd2, 0, 0, 0, "R9 sleeping");
        step(2'd2, 0, 0, 0, "R9 held line no wake");
        irq_raw = 8'h09;
        step(2'd2, 1, 1, 0, "R9 new disabled line wakes");
        clear_strobes(); sev = 0;
        step(2'd1, 1, 0, 0, "R9 returned");

        // R5 handler return
        isr_ret = 1;
        step(2'd1, 1, 0, 0, "R5 return no sleep-on-exit");
        isr_ret = 0;
        step(2'd1, 1, 0, 0, "R5 stays run");
        soe = 1; isr_ret = 1; irq_en = 8'h01;
        step(2'd1, 1, 0, 0, "R5 return with pending");
        clear_strobes();
        step(2'd1, 1, 0, 0, "R5 pending blocks");
        isr_ret = 1;
        step(2'd1, 1, 0, 0, "R5 return accepted");
        isr_ret = 0;
        step(2'd2, 0, 0, 0, "R5 sleeping");
        evt = 1;
        step(2'd2, 0, 0, 0, "R7 event ignored after return");
        evt = 0; irq_en = 8'h20;
        step(2'd2, 1, 1, 0, "R7 enabled irq wakes");
        clear_strobes(); soe = 0;
        step(2'd1, 1, 0, 0, "R7 returned");

        // R12 priority: WFI wins over WFE
        wfi = 1; wfe = 1; irq_en = 8'h01;
        step(2'd1, 1, 0, 0, "R12 both strobes wfi blocked");
        clear_strobes();
        step(2'd1, 1, 0, 0, "R12 no sleep");
        wfi = 1; wfe = 1;
        step(2'd1, 1, 0, 0, "R12 both strobes");
        wfi = 0; wfe = 0;
        step(2'd2, 0, 0, 0, "R12 sleeping");
        evt = 1;
        step(2'd2, 0, 0, 0, "R12 wfi rule applied");
        evt = 0; irq_en = 8'h01;
        step(2'd2, 1, 1, 0, "R12 irq wakes");
        clear_strobes();
        step(2'd1, 1, 0, 0, "R12 returned");

        // R2 run-level request ignored during sleep
        wfi = 1;
        step(2'd1, 1, 0, 0, "R2 wfi");
        wfi = 0; lp_run_req = 0;
        step(2'd2, 0, 0, 0, "R2 drop request in sleep");
        step(2'd2, 0, 0, 0, "R2 still asleep");
        irq_en = 8'h40;
        step(2'd2, 1, 1, 0, "R10 wake");
        clear_strobes();
        step(2'd1, 1, 0, 0, "R10 wake goes to low-power run");
        step(2'd0, 1, 0, 0, "R2 back to run");

        // R6 misplaced request
        wfi = 1;
        step(2'd0, 1, 0, 0, "R6 wfi in run");
        wfi = 0;
        step(2'd0, 1, 0, 1, "R6 ignored and flagged");
        step(2'd0, 1, 0, 1, "R6 flag sticky");
        lp_run_req = 1;
        step(2'd0, 1, 0, 1, "R6 request");
        step(2'd1, 1, 0, 1, "R6 flag kept");

        // R1 reset clears flag
        rst_n = 0;
        step(2'd1, 1, 0, 1, "R1 reset applied");
        step(2'd0, 1, 0, 0, "R1 reset cleared");

        @(negedge clk); @(negedge clk);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule